// File: doc/BRIEF.md
# Gated-Window Clock Frequency Meter

This block measures the rate of one internal clock, chosen from up to 128 candidates, by counting its edges during a gate window of programmable length. The window is timed by a 1 MHz reference strobe, so the count divided by the window length in microseconds gives the frequency in MHz. Software sees a small word-addressed register port with one control word, which holds the window length, the source index, enable, run and two stored-only mode bits, and a read-only busy flag. A separate result word holds the edge count.

A measurement goes like this. Software writes the window length minus one together with the source index, and sets enable and run in the same write. It then polls busy until it drops, clears enable and reads the count. The chosen clock is divided by two in its own domain and then passes through a synchroniser into the system clock domain. Each synchronised rising edge adds two to the count, so the count always stays even. The counter saturates at all ones, and that value marks an out-of-range reading. Writing all zeros to the control word aborts a measurement.

Top module: `freq_meter`

## Requirements
- R1: After reset the control word (offset 0x4) and the result word (offset 0xC) both read as zero.
- R2: Read data is registered and shows the addressed word one cycle after the address is presented. The control word stores duration in bits [15:0], enable in bit 16, continuous in bit 17, interrupt in bit 18, run in bit 19 and source in bits [26:20]. Bits [30:27] read zero and bit 31 reads busy; writes to bits [31:27] have no effect.
- R3: A control write with bits 16 and 19 both set while idle starts a measurement. Busy rises and the count clears to zero. A write that lacks either bit starts nothing.
- R4: With duration field D, busy falls on the (D+1)th reference tick after the start cycle. A tick in the start cycle itself is not counted.
- R5: The result word holds the count in bits [COUNT_W-1:0] with zeros above. Below saturation the count is even, and it is within 4 of the number of rising edges of the selected source while busy.
- R6: The count saturates at all ones (2^COUNT_W-1) and does not wrap.
- R7: A source index of NUM_SRC or above selects a constant input and yields a count of zero.
- R8: A control write while busy updates the stored fields. The running measurement keeps the source and duration latched at its start.
- R9: A write of all zeros to the control word clears busy at once and ends the measurement.
- R10: Offsets 0x0, 0x8 and every other unimplemented offset read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1us | input | 1 | One-cycle reference strobe, once per microsecond |
| src_clks | input | NUM_SRC | Candidate clocks to be measured |
| bus_addr | input | ADDR_W | Byte offset of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |

## Verification
The bench builds the meter with NUM_SRC = 8 and COUNT_W = 8. The narrow count lets a window of a hundred ticks drive the counter into saturation in a few thousand cycles. The eight-input mux leaves source indices 8 to 127 unconnected, which brings the constant-input path within reach. Window length, busy timing, field latching and abort are followed cycle by cycle against a behavioural model of the control word. The measured counts are checked against the source edges the bench itself sees while the window is open.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int DUR_W    = 16;
  localparam int SRC_W    = 7;
  localparam int CTRL_W   = 27;
  localparam int EN_BIT   = 16;
  localparam int CONT_BIT = 17;
  localparam int IRQ_BIT  = 18;
  localparam int RUN_BIT  = 19;
  localparam int SRC_LSB  = 20;
  localparam int BUSY_BIT = 31;
  localparam logic [3:0] OFS_CTRL = 4'h4;
  localparam logic [3:0] OFS_RES  = 4'hC;
endpackage

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int COUNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [31:0]          bus_wdata,
  input  logic                 busy,
  input  logic [COUNT_W-1:0]   count,
  output logic                 start,
  output logic                 abort,
  output logic [DUR_W-1:0]     start_dur,
  output logic [SRC_W-1:0]     start_src,
  output logic [31:0]          bus_rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFS_RES);

  logic [CTRL_W-1:0] ctrl_q;
  logic              wr_ctrl;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign abort     = wr_ctrl && (bus_wdata == 32'd0);
  assign start     = wr_ctrl && !busy && bus_wdata[EN_BIT] && bus_wdata[RUN_BIT];
  assign start_dur = bus_wdata[DUR_W-1:0];
  assign start_src = bus_wdata[SRC_LSB +: SRC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_addr == A_CTRL) begin
      bus_rdata <= {busy, {(BUSY_BIT-CTRL_W){1'b0}}, ctrl_q};
    end else if (bus_addr == A_RES) begin
      bus_rdata <= 32'(count);
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/fm_window.sv
module fm_window
  import fm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             abort,
  input  logic [DUR_W-1:0] start_dur,
  output logic             busy,
  output logic [DUR_W-1:0] left
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      left <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      left <= start_dur;
    end else if (busy && tick) begin
      if (left == '0) begin
        busy <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter
  import fm_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int COUNT_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic               start,
  input  logic               busy,
  input  logic [SRC_W-1:0]   start_src,
  output logic [SRC_W-1:0]   sel,
  output logic [COUNT_W-1:0] count
);
  localparam int FULL = 1 << SRC_W;
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic [FULL-1:0]  padded;
  logic             gate_q;
  logic             sel_clk;
  logic             half_q;
  logic [SYNC_N:0]  sync_q;
  logic             rise;

  generate
    if (NUM_SRC == FULL) begin : g_full
      assign padded = src_clks;
    end else begin : g_pad
      assign padded = {{(FULL-NUM_SRC){1'b0}}, src_clks};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= busy;
      if (start) sel <= start_src;
    end
  end

  assign sel_clk = gate_q & padded[sel];

  // divide by two in the measured domain
  always_ff @(posedge sel_clk) begin
    half_q <= ~half_q;
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_N-1:0], half_q};
  end

  assign rise = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

  always_ff @(posedge clk) begin
    if (rst || start) begin
      count <= '0;
    end else if (busy && rise) begin
      if (count >= CNT_MAX - COUNT_W'(1)) count <= CNT_MAX;
      else                                count <= count + COUNT_W'(2);
    end
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int NUM_SRC = 128,
  parameter int COUNT_W = 16,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_1us,
  input  logic [NUM_SRC-1:0] src_clks,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata
);
  logic               start_w;
  logic               abort_w;
  logic [DUR_W-1:0]   dur_w;
  logic [SRC_W-1:0]   src_w;
  logic               busy_w;
  logic [DUR_W-1:0]   left_w;
  logic [SRC_W-1:0]   sel_w;
  logic [COUNT_W-1:0] cnt_w;

  fm_regs #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .busy(busy_w), .count(cnt_w),
    .start(start_w), .abort(abort_w), .start_dur(dur_w),
    .start_src(src_w), .bus_rdata(bus_rdata)
  );

  fm_window u_win (
    .clk(clk), .rst(rst), .tick(tick_1us), .start(start_w),
    .abort(abort_w), .start_dur(dur_w), .busy(busy_w), .left(left_w)
  );

  fm_edge_counter #(.NUM_SRC(NUM_SRC), .COUNT_W(COUNT_W), .SYNC_N(SYNC_N)) u_cnt (
    .clk(clk), .rst(rst), .src_clks(src_clks), .start(start_w),
    .busy(busy_w), .start_src(src_w), .sel(sel_w), .count(cnt_w)
  );
endmodule

// File: rtl/freq_meter_checker.sv
module freq_meter_checker
  import fm_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               busy,
  input logic [DUR_W-1:0]   left,
  input logic [SRC_W-1:0]   sel,
  input logic [COUNT_W-1:0] count
);
  localparam logic [ADDR_W-1:0]  A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0]  A_RES   = ADDR_W'(OFS_RES);
  localparam logic [COUNT_W-1:0] CNT_MAX = '1;

  logic go;
  assign go = bus_wr && (bus_addr == A_CTRL) && !busy &&
              bus_wdata[EN_BIT] && bus_wdata[RUN_BIT];

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (rst)
    go |=> (busy && count == '0));

  assert_window_close_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && left == '0) |=> !busy);

  assert_count_even_R5: assert property (@(posedge clk) disable iff (rst)
    count[0] |-> (count == CNT_MAX));

  assert_sat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (count == CNT_MAX && !go) |=> (count == CNT_MAX));

  assert_src_latched_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(sel));

  assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == A_CTRL && bus_wdata == 32'd0) |=> !busy);

  assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_addr != A_CTRL && bus_addr != A_RES) |=> (bus_rdata == 32'd0));
endmodule

bind freq_meter freq_meter_checker #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_1us), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w), .left(left_w),
  .sel(sel_w), .count(cnt_w)
);

// File: tb/freq_meter_test.sv
module freq_meter_test;
  localparam int NSRC = 8;
  localparam int CW = 8;
  localparam int TICK_DIV = 10;
  localparam int CMAX = (1 << CW) - 1;
  localparam logic [31:0] RUNEN = 32'h0009_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic [3:0] bus_addr = 4'h4;
  logic bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  freq_meter #(.ADDR_W(4), .NUM_SRC(NSRC), .COUNT_W(CW)) uut (
    .clk(clk), .rst(rst), .tick_1us(tick), .src_clks(src),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  always #4 clk = ~clk;

  // source i has a half period of 12*(i+1) ns, kept off the system edges
  initial begin
    int t = 0;
    #1;
    forever begin
      #4;
      t++;
      for (int i = 0; i < NSRC; i++) if (t % (3 * (i + 1)) == 0) src[i] = ~src[i];
    end
  end

  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c = (c == TICK_DIV - 1) ? 0 : c + 1;
      tick = (c == 0);
    end
  end

  // behavioural reference model
  bit m_busy = 1'b0;
  logic [26:0] m_ctrl = '0;
  int m_left = 0;
  logic [6:0] m_sel = '0;
  bit exp_valid = 1'b0;
  logic [31:0] exp_rd = '0;
  int edge_total = 0;
  int edge_base = 0;

  wire tb_sel_clk = (m_sel < NSRC) ? src[m_sel[2:0]] : 1'b0;
  always @(posedge tb_sel_clk) if (m_busy) edge_total++;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 1'b0; m_ctrl = '0; m_left = 0;
      exp_valid = 1'b1; exp_rd = '0;
    end else begin
      exp_valid = (bus_addr != 4'hC);
      exp_rd = (bus_addr == 4'h4) ? {m_busy, 4'b0, m_ctrl} : 32'd0;
      if (bus_wr && bus_addr == 4'h4 && bus_wdata == 32'd0) begin
        m_busy = 1'b0;
      end else if (bus_wr && bus_addr == 4'h4 && !m_busy && bus_wdata[16] && bus_wdata[19]) begin
        m_busy = 1'b1;
        m_left = int'(bus_wdata[15:0]);
        m_sel = bus_wdata[26:20];
        edge_base = edge_total;
      end else if (m_busy && tick) begin
        if (m_left == 0) m_busy = 1'b0;
        else m_left--;
      end
      if (bus_wr && bus_addr == 4'h4) m_ctrl = bus_wdata[26:0];
    end
  end

  always @(negedge clk) begin
    if (exp_valid && !finished) begin
      compared++;
      if (bus_rdata !== exp_rd) begin
        mismatched++;
        $display("FAIL %s: per-cycle read data %h, expected %h", cur_req, bus_rdata, exp_rd);
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    bus_addr = 4'h4;
    @(negedge clk);
    while (bus_rdata[31]) @(negedge clk);
  endtask

  task automatic measure(input int s, input int d, output int cnt, output int edges);
    logic [31:0] v;
    wr(4'h4, (32'(s) << 20) | RUNEN | 32'(d - 1));
    wait_idle();
    edges = edge_total - edge_base;
    rd(4'hC, v);
    check(v[31:CW] == '0, "R5 upper bits", longint'(v), longint'(v[CW-1:0]));
    cnt = int'(v[CW-1:0]);
  endtask

  task automatic check_near(input string req, input int cnt, input int edges);
    int diff;
    diff = cnt - edges;
    if (diff < 0) diff = -diff;
    check((cnt % 2 == 0) && diff <= 4, req, cnt, edges);
  endtask

  initial begin
    logic [31:0] v;
    int cnt;
    int edges;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R1";
    rd(4'h4, v); check(v == 32'd0, "R1 control after reset", v, 0);
    rd(4'hC, v); check(v == 32'd0, "R1 result after reset", v, 0);

    cur_req = "R10";
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h8, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h0, v); check(v == 32'd0, "R10 offset 0x0", v, 0);
    rd(4'h8, v); check(v == 32'd0, "R10 offset 0x8", v, 0);
    rd(4'h4, v); check(v == 32'd0, "R10 control untouched", v, 0);

    cur_req = "R2";
    wr(4'h4, 32'hFD56_1234);
    rd(4'h4, v); check(v == 32'h0556_1234, "R2 field readback", v, 32'h0556_1234);
    cur_req = "R3";
    wr(4'h4, 32'h0018_0005);
    repeat (3) @(negedge clk);
    rd(4'h4, v); check(v == 32'h0018_0005, "R3 run without enable idle", v, 32'h0018_0005);
    wr(4'h4, 32'h0011_0005);
    repeat (3) @(negedge clk);
    rd(4'h4, v); check(v == 32'h0011_0005, "R3 enable without run idle", v, 32'h0011_0005);

    cur_req = "R4";
    measure(1, 20, cnt, edges);
    check_near("R5 source 1 window 20", cnt, edges);
    cur_req = "R5";
    measure(3, 30, cnt, edges);
    check_near("R5 source 3 window 30", cnt, edges);
    measure(0, 2, cnt, edges);
    check_near("R4 short window source 0", cnt, edges);

    cur_req = "R6";
    measure(0, 100, cnt, edges);
    check(cnt == CMAX, "R6 saturation", cnt, CMAX);
    measure(1, 3, cnt, edges);
    check(cnt < CMAX, "R3 count cleared after saturation", cnt, edges);

    cur_req = "R7";
    measure(9, 10, cnt, edges);
    check(cnt == 0, "R7 unconnected source", cnt, 0);

    cur_req = "R8";
    wr(4'h4, (32'd2 << 20) | RUNEN | 32'd24);
    repeat (50) @(negedge clk);
    wr(4'h4, RUNEN | 32'd3);
    repeat (100) @(negedge clk);
    rd(4'h4, v); check(v == 32'h8009_0003, "R8 still busy with new fields", v, 32'h8009_0003);
    wait_idle();
    edges = edge_total - edge_base;
    rd(4'hC, v);
    check_near("R8 count from latched source", int'(v), edges);

    cur_req = "R9";
    wr(4'h4, RUNEN | 32'd199);
    repeat (30) @(negedge clk);
    wr(4'h4, 32'd0);
    rd(4'h4, v); check(v == 32'd0, "R9 abort clears busy", v, 0);
    repeat (40) @(negedge clk);
    rd(4'h4, v); check(v == 32'd0, "R9 stays idle", v, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule